// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general-purpose registers of a 32-bit processor that runs in seven operating modes. Instructions name one of 16 architectural registers with a 4-bit number. The block turns that number and the current mode into one of 31 physical registers. Some modes get private copies of some registers, and all other registers are shared with the user bank. The block also keeps one saved status word for each of the five exception modes.

There are two combinational read ports and one mode-relative write port. A second write port always reaches the user-bank copy of a register. A privileged handler uses it to fill in user-mode state. The block does not decode instructions, does not change mode, and does not adjust the program-counter value.

Top module: `banked_regfile`

## Requirements
- R1: The 5-bit mode codes are user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. In user mode, system mode and any unlisted code, all 16 register numbers reach the user bank.
- R2: In fast-interrupt mode, registers 8 to 14 are private to that mode. Registers 0 to 7 and 15 are the user-bank copies.
- R3: The interrupt, supervisor, abort and undefined modes each own a private register 13 and register 14. Every other number reaches the user bank.
- R4: Read data follows the read address and the mode in the same cycle. A write lands on the rising clock edge, so a read of the register being written returns the old value in that cycle and the new value afterwards.
- R5: The user-bank write port ignores the mode and always updates the user-bank copy of the register it addresses.
- R6: If both write ports target the same physical register in one cycle, the mode-relative write port wins.
- R7: Each of the five exception modes has its own saved status word. It is written on the clock edge while its mode is current, and it is read combinationally while its mode is current.
- R8: In user mode, system mode or an unlisted code, the saved status output reads zero and a saved status write changes nothing.
- R9: Reset clears every physical register and every saved status word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 5 | Current operating mode code |
| rd_a_idx_i | input | 4 | Register number for read port A |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Register number for read port B |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Mode-relative write enable |
| wr_idx_i | input | 4 | Mode-relative write register number |
| wr_data_i | input | 32 | Mode-relative write data |
| usr_wr_en_i | input | 1 | User-bank write enable |
| usr_wr_idx_i | input | 4 | User-bank write register number |
| usr_wr_data_i | input | 32 | User-bank write data |
| sav_rd_data_o | output | 32 | Saved status word of the current mode |
| sav_wr_en_i | input | 1 | Saved status write enable |
| sav_wr_data_i | input | 32 | Saved status write data |

## Verification
Two events can meet in one cycle. The first is the two write ports landing on one physical register, which happens in user mode, or for any mode on the numbers shared with the user bank. The second is a read of a register that is being written in that same cycle. Directed steps drive both write ports at register 3 in user mode with different data and then read register 3. Other steps read a register while it is being written. Random traffic then makes both events happen again across every mode. Each cycle the outputs are compared against a reference model in the bench. That model applies the user-bank write first and the mode-relative write second, and it reads from state that was last updated at the previous edge.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

    localparam int ARCH_N  = 16;
    localparam int ARCH_W  = $clog2(ARCH_N);
    localparam int MODE_W  = 5;

    localparam logic [MODE_W-1:0] MD_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MD_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MD_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MD_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MD_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MD_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MD_SYS = 5'b11111;

    // Register bank selected by a mode; system and unlisted codes share user.
    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    localparam int FAST_LO   = 8;
    localparam int FAST_HI   = 14;
    localparam int FAST_N    = FAST_HI - FAST_LO + 1;
    localparam int PAIR_LO   = 13;
    localparam int PAIR_N    = ARCH_N - 1 - PAIR_LO;
    localparam int PAIR_MODES = 4;
    localparam int PHYS_N    = ARCH_N + FAST_N + PAIR_MODES * PAIR_N;
    localparam int PHYS_W    = $clog2(PHYS_N);
    localparam int SAV_N     = 1 + PAIR_MODES;
    localparam int SAV_W     = $clog2(SAV_N);

    typedef logic [PHYS_W-1:0] phys_t;

    function automatic bank_e mode_to_bank(input logic [MODE_W-1:0] m);
        case (m)
            MD_FIQ:  return BK_FIQ;
            MD_IRQ:  return BK_IRQ;
            MD_SVC:  return BK_SVC;
            MD_ABT:  return BK_ABT;
            MD_UND:  return BK_UND;
            default: return BK_USR;
        endcase
    endfunction

endpackage

// File: rtl/bankrf_map.sv
module bankrf_map
    import bankrf_pkg::*;
(
    input  bank_e             bank_i,
    input  logic [ARCH_W-1:0] arch_i,
    output phys_t             phys_o
);

    int arch_n;
    int bank_n;

    assign arch_n = int'(arch_i);
    assign bank_n = int'(bank_i);

    always_comb begin
        phys_o = phys_t'(arch_n);
        case (bank_i)
            BK_FIQ: begin
                if (arch_n >= FAST_LO && arch_n <= FAST_HI) begin
                    phys_o = phys_t'(ARCH_N + arch_n - FAST_LO);
                end
            end
            BK_IRQ, BK_SVC, BK_ABT, BK_UND: begin
                if (arch_n >= PAIR_LO && arch_n < PAIR_LO + PAIR_N) begin
                    phys_o = phys_t'(ARCH_N + FAST_N
                                     + (bank_n - int'(BK_IRQ)) * PAIR_N
                                     + arch_n - PAIR_LO);
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bankrf_gpr.sv
module bankrf_gpr #(
    parameter int DATA_W = 32,
    parameter int PHYS_N = 31,
    localparam int PHYS_W = $clog2(PHYS_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHYS_W-1:0] rda_idx_i,
    output logic [DATA_W-1:0] rda_data_o,
    input  logic [PHYS_W-1:0] rdb_idx_i,
    output logic [DATA_W-1:0] rdb_data_o,
    input  logic              mp_en_i,
    input  logic [PHYS_W-1:0] mp_idx_i,
    input  logic [DATA_W-1:0] mp_data_i,
    input  logic              up_en_i,
    input  logic [PHYS_W-1:0] up_idx_i,
    input  logic [DATA_W-1:0] up_data_i
);

    typedef struct packed {
        logic [PHYS_N-1:0][DATA_W-1:0] regs;
    } gpr_st_t;

    gpr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // User-bank port first so the mode-relative port overrides on collision.
        if (up_en_i && int'(up_idx_i) < PHYS_N) begin
            st_d.regs[up_idx_i] = up_data_i;
        end
        if (mp_en_i && int'(mp_idx_i) < PHYS_N) begin
            st_d.regs[mp_idx_i] = mp_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rda_data_o = (int'(rda_idx_i) < PHYS_N) ? st_q.regs[rda_idx_i] : '0;
    assign rdb_data_o = (int'(rdb_idx_i) < PHYS_N) ? st_q.regs[rdb_idx_i] : '0;

endmodule

// File: rtl/bankrf_sav.sv
module bankrf_sav #(
    parameter int DATA_W = 32,
    parameter int SAV_N  = 5,
    localparam int SAV_W = $clog2(SAV_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_valid_i,
    input  logic [SAV_W-1:0]  sel_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o
);

    typedef struct packed {
        logic [SAV_N-1:0][DATA_W-1:0] words;
    } sav_st_t;

    sav_st_t st_d, st_q;
    logic    sel_ok;

    assign sel_ok = sel_valid_i && (int'(sel_i) < SAV_N);

    always_comb begin
        st_d = st_q;
        if (wr_en_i && sel_ok) begin
            st_d.words[sel_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = sel_ok ? st_q.words[sel_i] : '0;

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bankrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_i,
    input  logic [3:0]        rd_a_idx_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [3:0]        rd_b_idx_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    input  logic              wr_en_i,
    input  logic [3:0]        wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              usr_wr_en_i,
    input  logic [3:0]        usr_wr_idx_i,
    input  logic [DATA_W-1:0] usr_wr_data_i,
    output logic [DATA_W-1:0] sav_rd_data_o,
    input  logic              sav_wr_en_i,
    input  logic [DATA_W-1:0] sav_wr_data_i
);

    localparam int MAP_N = 4;

    bank_e             cur_bank;
    bank_e             map_bank [MAP_N];
    logic [ARCH_W-1:0] map_arch [MAP_N];
    phys_t             map_phys [MAP_N];
    logic              sav_valid;
    logic [SAV_W-1:0]  sav_sel;

    assign cur_bank = mode_to_bank(mode_i);

    // Port 0/1: reads, port 2: mode-relative write, port 3: user-bank write.
    assign map_bank[0] = cur_bank;
    assign map_bank[1] = cur_bank;
    assign map_bank[2] = cur_bank;
    assign map_bank[3] = BK_USR;
    assign map_arch[0] = rd_a_idx_i;
    assign map_arch[1] = rd_b_idx_i;
    assign map_arch[2] = wr_idx_i;
    assign map_arch[3] = usr_wr_idx_i;

    for (genvar g = 0; g < MAP_N; g++) begin : g_map
        bankrf_map u_map (
            .bank_i (map_bank[g]),
            .arch_i (map_arch[g]),
            .phys_o (map_phys[g])
        );
    end

    bankrf_gpr #(
        .DATA_W (DATA_W),
        .PHYS_N (PHYS_N)
    ) u_gpr (
        .clk        (clk),
        .rst_n      (rst_n),
        .rda_idx_i  (map_phys[0]),
        .rda_data_o (rd_a_data_o),
        .rdb_idx_i  (map_phys[1]),
        .rdb_data_o (rd_b_data_o),
        .mp_en_i    (wr_en_i),
        .mp_idx_i   (map_phys[2]),
        .mp_data_i  (wr_data_i),
        .up_en_i    (usr_wr_en_i),
        .up_idx_i   (map_phys[3]),
        .up_data_i  (usr_wr_data_i)
    );

    assign sav_valid = (cur_bank != BK_USR);
    assign sav_sel   = SAV_W'(cur_bank) - SAV_W'(1);

    bankrf_sav #(
        .DATA_W (DATA_W),
        .SAV_N  (SAV_N)
    ) u_sav (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_valid_i (sav_valid),
        .sel_i       (sav_sel),
        .wr_en_i     (sav_wr_en_i),
        .wr_data_i   (sav_wr_data_i),
        .rd_data_o   (sav_rd_data_o)
    );

endmodule

// File: rtl/bankrf_chk.sv
module bankrf_chk
    import bankrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        mode_i,
    input logic [3:0]        rd_a_idx_i,
    input logic [DATA_W-1:0] rd_a_data_o,
    input logic [3:0]        rd_b_idx_i,
    input logic [DATA_W-1:0] rd_b_data_o,
    input logic              wr_en_i,
    input logic [3:0]        wr_idx_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              usr_wr_en_i,
    input logic [3:0]        usr_wr_idx_i,
    input logic [DATA_W-1:0] usr_wr_data_i,
    input logic [DATA_W-1:0] sav_rd_data_o,
    input logic              sav_wr_en_i,
    input logic [DATA_W-1:0] sav_wr_data_i
);

    logic user_view;
    assign user_view = (mode_to_bank(mode_i) == BK_USR);

    // R4: a write shows up on the next cycle's read in the same mode
    p_wr_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en_i) && mode_i == $past(mode_i) && rd_a_idx_i == $past(wr_idx_i))
        |-> rd_a_data_o == $past(wr_data_i));

    // R5: the user-bank port write is seen from user view
    p_usr_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(usr_wr_en_i) && !$past(wr_en_i) && user_view
         && rd_b_idx_i == $past(usr_wr_idx_i))
        |-> rd_b_data_o == $past(usr_wr_data_i));

    // R6: mode-relative port wins a same-register collision in user view
    p_port_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en_i && usr_wr_en_i && wr_idx_i == usr_wr_idx_i)
         && $past(mode_i) == MD_USR && mode_i == MD_USR
         && rd_b_idx_i == $past(wr_idx_i))
        |-> rd_b_data_o == $past(wr_data_i));

    // R7: saved status word holds while mode and write enable are quiet
    p_sav_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(sav_wr_en_i) && $stable(mode_i)) |-> $stable(sav_rd_data_o));

    // R8: no saved status word in user view
    p_sav_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        user_view |-> sav_rd_data_o == '0);

endmodule

bind banked_regfile bankrf_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .rd_a_idx_i    (rd_a_idx_i),
    .rd_a_data_o   (rd_a_data_o),
    .rd_b_idx_i    (rd_b_idx_i),
    .rd_b_data_o   (rd_b_data_o),
    .wr_en_i       (wr_en_i),
    .wr_idx_i      (wr_idx_i),
    .wr_data_i     (wr_data_i),
    .usr_wr_en_i   (usr_wr_en_i),
    .usr_wr_idx_i  (usr_wr_idx_i),
    .usr_wr_data_i (usr_wr_data_i),
    .sav_rd_data_o (sav_rd_data_o),
    .sav_wr_en_i   (sav_wr_en_i),
    .sav_wr_data_i (sav_wr_data_i)
);

// File: tb/banked_regfile_tb_top.sv
`timescale 1ns/1ps
module banked_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  mode;
    logic [3:0]  ra, rb, widx, uidx;
    logic [31:0] rda, rdb, wdata, udata, sav_rd, sav_wd;
    logic        wen, uen, sen;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] m_usr [16];
    logic [31:0] m_fiq [7];
    logic [31:0] m_exc [4][2];
    logic [31:0] m_sav [5];

    logic [4:0] mode_list [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                  5'b10111, 5'b11011, 5'b11111, 5'b00110};

    always #2.5 clk = ~clk;

    banked_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .rd_a_idx_i(ra), .rd_a_data_o(rda),
        .rd_b_idx_i(rb), .rd_b_data_o(rdb),
        .wr_en_i(wen), .wr_idx_i(widx), .wr_data_i(wdata),
        .usr_wr_en_i(uen), .usr_wr_idx_i(uidx), .usr_wr_data_i(udata),
        .sav_rd_data_o(sav_rd), .sav_wr_en_i(sen), .sav_wr_data_i(sav_wd)
    );

    // 0 user view, 1 fast interrupt, 2..5 modes with a private r13/r14
    function automatic int bk(input logic [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic logic [31:0] mread(input logic [4:0] m, input logic [3:0] r);
        int b = bk(m);
        int ri = int'(r);
        if (b == 1 && ri >= 8 && ri <= 14) return m_fiq[ri-8];
        if (b >= 2 && (ri == 13 || ri == 14)) return m_exc[b-2][ri-13];
        return m_usr[ri];
    endfunction

    task automatic mwrite(input logic [4:0] m, input logic [3:0] r, input logic [31:0] d);
        int b = bk(m);
        int ri = int'(r);
        if (b == 1 && ri >= 8 && ri <= 14) m_fiq[ri-8] = d;
        else if (b >= 2 && (ri == 13 || ri == 14)) m_exc[b-2][ri-13] = d;
        else m_usr[ri] = d;
    endtask

    function automatic logic [31:0] msav(input logic [4:0] m);
        int b = bk(m);
        return (b == 0) ? 32'h0 : m_sav[b-1];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: mode=%b actual=%h expected=%h", tag, mode, act, exp);
        end
    endtask

    function automatic string rtag(input logic [3:0] idx);
        int b = bk(mode);
        if (!rst_n) return "R9";
        if (wen && idx == widx) return "R4";
        if (b == 1) return "R2";
        if (b >= 2) return "R3";
        return "R1";
    endfunction

    // Compare at mid-cycle, then let the edge happen and update the model.
    task automatic cycle(input string tag);
        #1;
        chk(tag != "" ? tag : rtag(ra), rda, mread(mode, ra));
        chk(tag != "" ? tag : rtag(rb), rdb, mread(mode, rb));
        chk(tag != "" ? tag : (!rst_n ? "R9" : (bk(mode) == 0 ? "R8" : "R7")),
            sav_rd, msav(mode));
        @(posedge clk);
        if (rst_n) begin
            if (uen) mwrite(5'b10000, uidx, udata);
            if (wen) mwrite(mode, widx, wdata);
            if (sen && bk(mode) != 0) m_sav[bk(mode)-1] = sav_wd;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        wen = 0; uen = 0; sen = 0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_usr[i] = '0;
        for (int i = 0; i < 7; i++) m_fiq[i] = '0;
        for (int i = 0; i < 4; i++) for (int j = 0; j < 2; j++) m_exc[i][j] = '0;
        for (int i = 0; i < 5; i++) m_sav[i] = '0;
        rst_n = 0; mode = 5'b10000; ra = 0; rb = 0; widx = 0; uidx = 0;
        wdata = 0; udata = 0; sav_wd = 0;
        idle();
        @(negedge clk);
        // R9: everything reads zero while in reset
        for (int k = 0; k < 8; k++) begin
            mode = mode_list[k]; ra = 4'd13; rb = 4'd9;
            cycle("R9");
        end
        rst_n = 1;
        mode = 5'b10000;
        for (int r = 0; r < 16; r++) begin
            ra = 4'(r); rb = 4'(15 - r);
            cycle("R9");
        end

        // Fill user bank (R1)
        for (int r = 0; r < 16; r++) begin
            wen = 1; widx = 4'(r); wdata = 32'h1000_0000 + 32'(r);
            ra = 4'(r); rb = 4'((r + 1) % 16);
            cycle("");
        end
        // Fill fast-interrupt bank (R2)
        mode = 5'b10001;
        for (int r = 8; r < 15; r++) begin
            wen = 1; widx = 4'(r); wdata = 32'h2000_0000 + 32'(r);
            ra = 4'(r); rb = 4'(r - 8);
            cycle("");
        end
        wen = 0; sen = 1; sav_wd = 32'h5000_00F0; cycle("R7");
        // Fill pair banks and saved status words (R3, R7)
        for (int k = 2; k < 6; k++) begin
            mode = mode_list[k];
            sen = 1; sav_wd = 32'h5000_0000 + 32'(k);
            wen = 1; widx = 4'd13; wdata = 32'h3000_0013 + 32'(k << 8);
            ra = 4'd13; rb = 4'd8;
            cycle("");
            sen = 0; widx = 4'd14; wdata = 32'h3000_0014 + 32'(k << 8);
            ra = 4'd14; rb = 4'd13;
            cycle("");
        end
        idle();

        // Sweep every mode over every register (R1 R2 R3 R7 R8)
        for (int k = 0; k < 8; k++) begin
            mode = mode_list[k];
            for (int r = 0; r < 16; r++) begin
                ra = 4'(r); rb = 4'(15 - r);
                cycle("");
            end
        end

        // R4: read during write returns old value, then new
        mode = 5'b10010; wen = 1; widx = 4'd13; wdata = 32'hAAAA_0413; ra = 4'd13; rb = 4'd14;
        #1 chk("R4", rda, 32'h3000_0213);
        cycle("R4");
        idle();
        #1 chk("R4", rda, 32'hAAAA_0413);
        cycle("R4");

        // R5: user-bank write from supervisor mode
        mode = 5'b10011; uen = 1; uidx = 4'd13; udata = 32'hCAFE_0013; ra = 4'd13; rb = 4'd13;
        cycle("R5");
        idle();
        #1 chk("R5", rda, 32'h3000_0313);
        cycle("R5");
        mode = 5'b10000;
        #1 chk("R5", rda, 32'hCAFE_0013);
        cycle("R5");

        // R6: both ports on user r3
        wen = 1; widx = 4'd3; wdata = 32'h6666_0001;
        uen = 1; uidx = 4'd3; udata = 32'h6666_0002;
        ra = 4'd3; rb = 4'd3;
        cycle("R6");
        idle();
        #1 chk("R6", rda, 32'h6666_0001);
        cycle("R6");

        // R8: saved status write in user and system mode is ignored
        mode = 5'b10000; sen = 1; sav_wd = 32'hDEAD_BEEF;
        #1 chk("R8", sav_rd, 32'h0);
        cycle("R8");
        mode = 5'b11111;
        cycle("R8");
        idle();
        mode = 5'b10010;
        #1 chk("R8", sav_rd, 32'h5000_0002);
        cycle("R8");

        // Random traffic across all modes
        for (int i = 0; i < 4000; i++) begin
            mode   = mode_list[$urandom_range(7)];
            ra     = 4'($urandom_range(15));
            rb     = 4'($urandom_range(15));
            wen    = ($urandom_range(2) != 0);
            widx   = 4'($urandom_range(15));
            wdata  = $urandom;
            uen    = ($urandom_range(3) == 0);
            uidx   = ($urandom_range(1) == 0) ? widx : 4'($urandom_range(15));
            udata  = $urandom;
            sen    = ($urandom_range(3) == 0);
            sav_wd = $urandom;
            cycle("");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule